// File: doc/BRIEF.md
# Prioritized Chip-Select Decoder with Boot Mode

This unit turns a bus address, a 3-bit function code and a read/write flag into one of four active-low chip selects. It then times the access with a programmed number of wait states and returns a port-size acknowledge. Each select has two 32-bit configuration words written through a small register port:

- **Base word:** comparison address, function code, write-protect flag and enable flag.
- **Option word:** don't-care mask, function-code mask, port size and wait count.

After reset, select 0 runs in a boot mode. It claims every access and answers as a 16-bit port after three wait states, so that the first vectors can be fetched from address zero. All other selects stay silent in this mode. Boot mode ends when software writes select 0's base word with the enable flag set. From then on select 0 decodes whatever range that write loaded. Only a reset brings boot mode back.

An access starts when the address strobe is first sampled low, and it ends when the strobe is sampled high. An external 8-bit acknowledge can cancel the internal one if it arrives early enough.

Top module: `csel_unit`

## Requirements
- R1: When several enabled selects match an access, only the lowest-numbered one asserts. Across the four cs_n outputs at most one is low at any time.
- R2: After reset, all cs_n and dsack_n outputs are high. Select 0 then asserts for every address (including 0x00000000 and 0x00000004), every function code, and both reads and writes.
- R3: In boot mode the acknowledge is the 16-bit code dsack_n = 2'b01, and it comes after 3 wait states.
- R4: In boot mode cs_n[3:1] stay high whatever their configuration words hold.
- R5: A write to select 0's base word (reg_addr = 3'b000) with bit 0 set ends boot mode. A write to the same word with bit 0 clear leaves boot mode in force.
- R6: Once boot mode has ended, clearing select 0's enable bit does not restore it. Only rst_n low restores it.
- R7: Outside boot mode, select i matches when all of the following hold:
  - base bit 0 (enable) is 1;
  - addr[31:8] equals base[31:8] at every bit where option[31:8] is 0;
  - fc equals base[7:5] at every bit where option[7:5] is 0.
- R8: When base bit 1 (write protect) is set, a write access (rw = 0) does not match that select.
- R9: The acknowledge comes W+1 clock edges after the edge that first samples as_n low, where W = option[3:0]. Its code is 2'b10 when option bit 4 is 1 (8-bit port) and 2'b01 otherwise. An access that no select matches is never acknowledged.
- R10: If ext_ack8_n is sampled low while the wait counter is at 2 or below, the internal acknowledge is suppressed for that access. Sampled later, it has no effect.
- R11: At the edge that samples as_n high, all cs_n and dsack_n outputs return high.
- R12: Register address {i, 0} writes select i's base word and {i, 1} writes its option word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_addr | input | 3 | {select index, 0 = base / 1 = option} |
| reg_wdata | input | 32 | Configuration write data |
| as_n | input | 1 | Active-low address strobe |
| addr | input | 32 | Bus address |
| fc | input | 3 | Function code |
| rw | input | 1 | 1 = read, 0 = write |
| ext_ack8_n | input | 1 | External 8-bit acknowledge, active low |
| cs_n | output | 4 | Active-low chip selects |
| dsack_n | output | 2 | Acknowledge code: 01 = 16-bit, 10 = 8-bit, 11 = none |

## Verification
Call the edge that first samples the strobe low the capture edge. The selected cs_n is visible after the capture edge. The acknowledge follows W+1 edges later, and outputs go idle one edge after the strobe rises.

The bench drives every input on a falling edge and reads the outputs only on falling edges:
- It reads cs_n on the first falling edge after the strobe.
- It derives the wait count from the index of the falling edge where dsack_n first leaves 11, which is W+2.
- It checks idle one falling edge after releasing the strobe.

External-acknowledge timing is tested on both sides of the limit. Injecting it on the third falling edge lands on counter value 2. Injecting it on the fourth lands on counter value 3.

// File: rtl/csel_unit.sv
module csel_unit #(
  parameter int NCS   = 4,
  parameter int WSW   = 4,
  parameter int GWAIT = 3,
  parameter int EXTW  = 2,
  localparam int IW   = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [IW:0]    reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic           as_n,
  input  logic [31:0]    addr,
  input  logic [2:0]     fc,
  input  logic           rw,
  input  logic           ext_ack8_n,
  output logic [NCS-1:0] cs_n,
  output logic [1:0]     dsack_n
);

  logic [31:0]    base_q [NCS];
  logic [31:0]    opt_q  [NCS];
  logic           glob_q;
  logic           active_q, ack_q, ext_q, s8_q;
  logic [NCS-1:0] sel_q, hit, win;
  logic [WSW-1:0] cnt_q, wt_q, w_sel;
  logic           s8_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_q <= 1'b1;
      for (int i = 0; i < NCS; i++) begin
        base_q[i] <= '0;
        opt_q[i]  <= '0;
      end
    end else if (reg_we) begin
      if (reg_addr[0]) opt_q[reg_addr[IW:1]]  <= reg_wdata;
      else             base_q[reg_addr[IW:1]] <= reg_wdata;
      if (!reg_addr[0] && reg_addr[IW:1] == '0 && reg_wdata[0]) glob_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_match
    wire adr_ok = ((addr ^ base_q[i]) & ~opt_q[i] & 32'hFFFF_FF00) == '0;
    wire fc_ok  = ((fc ^ base_q[i][7:5]) & ~opt_q[i][7:5]) == '0;
    wire wp_ok  = !(base_q[i][1] && !rw);
    assign hit[i] = glob_q ? (i == 0) : (base_q[i][0] && adr_ok && fc_ok && wp_ok);
  end

  assign win = hit & (~hit + NCS'(1));

  always_comb begin
    w_sel  = '0;
    s8_sel = 1'b0;
    for (int i = 0; i < NCS; i++)
      if (win[i]) begin
        w_sel  = opt_q[i][WSW-1:0];
        s8_sel = opt_q[i][WSW];
      end
    if (glob_q) begin
      w_sel  = WSW'(GWAIT);
      s8_sel = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || as_n) begin
      active_q <= 1'b0;
      sel_q    <= '0;
      ack_q    <= 1'b0;
      ext_q    <= 1'b0;
      cnt_q    <= '0;
      wt_q     <= '0;
      s8_q     <= 1'b0;
    end else if (!active_q) begin
      active_q <= 1'b1;
      sel_q    <= win;
      wt_q     <= w_sel;
      s8_q     <= s8_sel;
      cnt_q    <= '0;
    end else if (!ack_q && !ext_q) begin
      if (!ext_ack8_n && cnt_q <= WSW'(EXTW)) ext_q <= 1'b1;
      else if (cnt_q == wt_q && |sel_q)       ack_q <= 1'b1;
      else if (cnt_q != wt_q)                 cnt_q <= cnt_q + WSW'(1);
    end
  end

  assign cs_n    = ~sel_q;
  assign dsack_n = ack_q ? (s8_q ? 2'b10 : 2'b01) : 2'b11;

endmodule

module csel_unit_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           as_n,
  input logic [NCS-1:0] cs_n,
  input logic [1:0]     dsack_n,
  input logic           glob
);

  a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r4_boot_silences_others: assert property (@(posedge clk) disable iff (!rst_n)
    glob |-> (cs_n[NCS-1:1] == '1));

  a_r6_boot_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(glob));

  a_r9_ack_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (dsack_n != 2'b11) |-> (cs_n != '1));

  a_r10_single_ack_code: assert property (@(posedge clk) disable iff (!rst_n)
    dsack_n != 2'b00);

  a_r11_idle_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (cs_n == '1 && dsack_n == 2'b11));

endmodule

bind csel_unit csel_unit_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_n(cs_n),
  .dsack_n(dsack_n), .glob(glob_q)
);

// File: tb/csel_unit_bench.sv
module csel_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, addr = '0;
  logic        as_n = 1'b1, rw = 1'b1, ext_ack8_n = 1'b1;
  logic [2:0]  fc = '0;
  logic [3:0]  cs_n;
  logic [1:0]  dsack_n;

  int nchk = 0, nfail = 0;
  logic [31:0] mb [4];
  logic [31:0] mo [4];
  bit tglob;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_unit u_csel_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .as_n(as_n), .addr(addr), .fc(fc), .rw(rw),
    .ext_ack8_n(ext_ack8_n), .cs_n(cs_n), .dsack_n(dsack_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tglob = 1'b1;
    for (int i = 0; i < 4; i++) begin mb[i] = '0; mo[i] = '0; end
  endtask

  // R12: address {idx, isopt}
  task automatic wr(input int idx, input bit isopt, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {idx[1:0], isopt}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (isopt) mo[idx] = d; else mb[idx] = d;
    if (idx == 0 && !isopt && d[0]) tglob = 1'b0;
  endtask

  function automatic int mwin(logic [31:0] a, logic [2:0] f, logic r);
    if (tglob) return 0;
    for (int i = 0; i < 4; i++)
      if (mb[i][0] && (((a ^ mb[i]) & ~mo[i] & 32'hFFFF_FF00) == 0) &&
          (((f ^ mb[i][7:5]) & ~mo[i][7:5]) == 0) && !(mb[i][1] && !r))
        return i;
    return -1;
  endfunction

  task automatic cyc(input logic [31:0] a, input logic [2:0] f, input logic r,
                     input int ext_at, output logic [3:0] cs, output int waits,
                     output logic [1:0] ds);
    @(negedge clk);
    addr = a; fc = f; rw = r; as_n = 1'b0;
    waits = -1; ds = 2'b11; cs = '1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == 1) cs = cs_n;
      if (waits < 0 && dsack_n != 2'b11) begin waits = i - 2; ds = dsack_n; end
      if (i == ext_at) ext_ack8_n = 1'b0;
    end
    as_n = 1'b1; ext_ack8_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'hF && dsack_n == 2'b11, "R11 idle", {cs_n, dsack_n}, 6'h3F);
  endtask

  task automatic expect_model(input logic [31:0] a, input logic [2:0] f,
                              input logic r, input string req);
    logic [3:0] cs; int w; logic [1:0] ds;
    int k, ew; logic [1:0] eds; logic [3:0] ecs;
    k = mwin(a, f, r);
    ecs = (k < 0) ? 4'hF : ~(4'b1 << k);
    ew  = tglob ? 3 : (k < 0) ? -1 : int'(mo[k][3:0]);
    eds = (k < 0) ? 2'b11 : (!tglob && mo[k][4]) ? 2'b10 : 2'b01;
    cyc(a, f, r, -1, cs, w, ds);
    chk(cs == ecs, {req, " select"}, cs, ecs);
    chk(w == ew, {req, " R9 waits"}, w, ew);
    chk(ds == eds, {req, " R9 size"}, ds, eds);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] gaddr [4];
    logic [31:0] sweep [9];
    logic [3:0] cs; int w; logic [1:0] ds;
    gaddr = '{32'h0, 32'h4, 32'h0012_3456, 32'hFFFF_FFFC};
    sweep = '{32'h0, 32'h8000, 32'h1_0000, 32'hF_FFF0, 32'h10_0000,
              32'h18_0000, 32'h20_0000, 32'h30_0000, 32'h1000_0000};
    do_reset();
    @(negedge clk);
    chk(cs_n == 4'hF && dsack_n == 2'b11, "R2 reset outputs", {cs_n, dsack_n}, 6'h3F);

    // R2, R3: boot mode over addresses, function codes, both directions
    foreach (gaddr[j])
      for (int f = 0; f < 8; f++)
        for (int r = 0; r < 2; r++)
          expect_model(gaddr[j], f[2:0], r[0], "R2 R3 boot");

    // R4, R5: configure the other selects and load base 0 without enable
    wr(1, 0, 32'h0000_0003); wr(1, 1, 32'h000F_FFF1);
    wr(2, 0, 32'h0010_00A1); wr(2, 1, 32'h000F_FF00);
    wr(3, 0, 32'h0010_0001); wr(3, 1, 32'h001F_FFF5);
    wr(0, 1, 32'h0000_FFE2); wr(0, 0, 32'h0000_0000);
    foreach (sweep[j]) begin
      cyc(sweep[j], 3'd5, 1'b1, -1, cs, w, ds);
      chk(cs == 4'b1110, "R4 R5 boot kept", cs, 4'b1110);
    end

    // R10: external 8-bit acknowledge at counter 2 and at counter 3
    cyc(32'h100, 3'd1, 1'b1, 3, cs, w, ds);
    chk(w == -1, "R10 early external suppresses", w, -1);
    cyc(32'h100, 3'd1, 1'b1, 4, cs, w, ds);
    chk(w == 3 && ds == 2'b01, "R10 late external ignored", w, 3);

    // R5: enabling select 0 ends boot mode
    wr(0, 0, 32'h0000_0001);
    // R1, R7, R8, R9: decoded sweep
    foreach (sweep[j])
      for (int f = 0; f < 8; f++)
        for (int r = 0; r < 2; r++)
          expect_model(sweep[j], f[2:0], r[0], "R1 R7 R8 decode");

    // R6: clearing enable does not restore boot mode
    wr(0, 0, 32'h0000_0000);
    cyc(32'h0, 3'd0, 1'b1, -1, cs, w, ds);
    chk(cs == 4'b1101, "R6 no boot after clear", cs, 4'b1101);
    cyc(32'h20_0000, 3'd0, 1'b1, -1, cs, w, ds);
    chk(cs == 4'b1111 && w == -1, "R6 R9 no match no ack", cs, 4'b1111);

    // R6: reset restores boot mode
    do_reset();
    cyc(32'h20_0000, 3'd2, 1'b0, -1, cs, w, ds);
    chk(cs == 4'b1110 && w == 3, "R6 boot after reset", cs, 4'b1110);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule